// File: doc/BRIEF.md
# Sync Header Word Assembler

This block sits on the receive side of a 64b/66b lane. It rebuilds the slow side channel that travels in the 2-bit sync headers of the received blocks. Each valid block carries one header. The header is turned into a single bit, and an illegal header code is flagged. Thirty-two consecutive bits, one per block of a multiblock, are assembled into a sync word. The block then presents that word with a one-cycle strobe. Interpreting the word contents is left to the logic downstream.

The block locks to multiblock boundaries through a start strobe supplied by the local extended-multiblock clock logic. The strobe arrives together with the first block of each multiblock. A long unbroken run of illegal headers drops the lock. While the lock is down, no words are produced. The lock comes back at the next multiblock start. A word that a premature start strobe cuts short is thrown away.

Top module: `shdr_word_rx`

## Requirements
- R1: A header of binary 10 decodes to bit 1 and a header of binary 01 decodes to bit 0.
- R2: Headers 00 and 11 are illegal. Each one raises `hdr_err` in the cycle after its block and enters the word as bit 0.
- R3: The bit from the block that carries `mb_start` lands in the most significant bit of `sync_word`. Later blocks fill the lower bits in arrival order.
- R4: `word_vld` is high for exactly one cycle. That cycle follows the clock edge that captured the 32nd block of a multiblock, and `sync_word` holds the new word in it.
- R5: When `mb_start` arrives before 32 blocks have been collected, the partial word is discarded without a `word_vld` pulse, and collection restarts from that block.
- R6: Sixteen illegal headers in a row, with no `mb_start` among them, clear `locked` in the cycle after the 16th. Fifteen in a row do not clear it, and any legal header restarts the run.
- R7: `locked` rises only in the cycle after a block that carries `mb_start`. While `locked` is low, no word is assembled.
- R8: After reset, `locked`, `word_vld` and `hdr_err` are 0 and `sync_word` is all zeros.
- R9: While `blk_vld` is low, `blk_hdr` and `mb_start` have no effect on any output or on the word being assembled.
- R10: Blocks that arrive after a word completes and before the next `mb_start` are not collected, and `sync_word` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| blk_vld | input | 1 | A received block is present this cycle |
| blk_hdr | input | 2 | Sync header of the present block |
| mb_start | input | 1 | Present block is the first of a multiblock |
| sync_word | output | 32 | Last complete sync word, first block in the MSB |
| word_vld | output | 1 | One-cycle strobe marking a new `sync_word` |
| hdr_err | output | 1 | Previous block carried an illegal header |
| locked | output | 1 | Aligned to multiblock boundaries |

## Verification
The hardest state to reach from the ports is the edge of lock loss. A run of exactly fifteen illegal headers must leave the lock untouched. A sixteenth must drop it, and a multiblock start must end the run. Directed sequences step through 15, one legal header, and then 16 illegal headers. The random phase injects bursts of eighteen bad headers over a steady multiblock cadence, which also interrupts words mid-collection. Early start strobes and idle cycles carrying junk headers are mixed in to cover dropped partial words and ignored inputs.

// File: rtl/shdr_pkg.sv
package shdr_pkg;

   localparam logic [1:0] HDR_CODE_ZERO = 2'b01;
   localparam logic [1:0] HDR_CODE_ONE  = 2'b10;

   typedef struct packed {
      logic bit_val;
      logic illegal;
   } hdr_dec_t;

   function automatic hdr_dec_t decode_hdr(input logic [1:0] code);
      hdr_dec_t d;
      d.bit_val = (code == HDR_CODE_ONE);
      d.illegal = (code != HDR_CODE_ONE) && (code != HDR_CODE_ZERO);
      return d;
   endfunction

endpackage

// File: rtl/shdr_hdr_decode.sv
module shdr_hdr_decode
   import shdr_pkg::*;
(
   input  logic       blk_vld,
   input  logic [1:0] hdr_in,
   output logic       bit_out,
   output logic       bad_out
);

   hdr_dec_t dec;

   always_comb begin
      dec     = decode_hdr(hdr_in);
      bit_out = dec.bit_val;
      bad_out = blk_vld && dec.illegal;
   end

endmodule

// File: rtl/shdr_lock_track.sv
module shdr_lock_track #(
   parameter int LOSS_COUNT = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic blk_vld,
   input  logic start,
   input  logic bad,
   output logic locked_o,
   output logic lose_o
);

   localparam int CW = $clog2(LOSS_COUNT + 1);
   localparam logic [CW-1:0] RUN_MAX = CW'(LOSS_COUNT);

   logic [CW-1:0] run_q, run_nxt;
   logic          lock_q, lock_nxt;

   always_comb begin
      run_nxt = run_q;
      if (blk_vld) begin
         if (start)
            run_nxt = bad ? CW'(1) : '0;
         else if (bad)
            run_nxt = (run_q == RUN_MAX) ? run_q : run_q + CW'(1);
         else
            run_nxt = '0;
      end
      lose_o   = blk_vld && !start && bad && (run_nxt == RUN_MAX);
      lock_nxt = lock_q;
      if (blk_vld && start)
         lock_nxt = 1'b1;
      else if (lose_o)
         lock_nxt = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q  <= '0;
         lock_q <= 1'b0;
      end else begin
         run_q  <= run_nxt;
         lock_q <= lock_nxt;
      end
   end

   assign locked_o = lock_q;

   // R6
   run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run_q <= RUN_MAX);

   // R6
   loss_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q == RUN_MAX - CW'(1)) && blk_vld && bad && !start |=> !locked_o);

   // R6
   short_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      locked_o && (run_q < RUN_MAX - CW'(1)) && !(blk_vld && start) |=> locked_o);

endmodule

// File: rtl/shdr_word_collect.sv
module shdr_word_collect #(
   parameter int WORD_BITS = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 blk_vld,
   input  logic                 start,
   input  logic                 bit_in,
   input  logic                 lose,
   output logic [WORD_BITS-1:0] word_o,
   output logic                 vld_o
);

   localparam int IW = $clog2(WORD_BITS + 1);
   localparam logic [IW-1:0] IDX_FULL = IW'(WORD_BITS);

   logic                 active_q;
   logic [IW-1:0]        idx_q, idx_nxt;
   logic [WORD_BITS-1:0] sh_q, sh_nxt;
   logic                 take, done;

   always_comb begin
      take    = blk_vld && !lose && (start || active_q);
      sh_nxt  = start ? {{(WORD_BITS-1){1'b0}}, bit_in} : {sh_q[WORD_BITS-2:0], bit_in};
      idx_nxt = start ? IW'(1) : idx_q + IW'(1);
      done    = take && (idx_nxt == IDX_FULL);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         idx_q    <= '0;
         sh_q     <= '0;
         word_o   <= '0;
         vld_o    <= 1'b0;
      end else begin
         vld_o <= 1'b0;
         if (blk_vld && lose) begin
            active_q <= 1'b0;
            idx_q    <= '0;
         end else if (take) begin
            sh_q     <= sh_nxt;
            idx_q    <= idx_nxt;
            active_q <= !done;
            if (done) begin
               word_o <= sh_nxt;
               vld_o  <= 1'b1;
            end
         end
      end
   end

   // R4
   vld_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vld_o |=> !vld_o);

   // R4
   idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      idx_q <= IDX_FULL);

   // R10
   word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !vld_o |-> word_o == $past(word_o));

endmodule

// File: rtl/shdr_word_rx.sv
module shdr_word_rx #(
   parameter int WORD_BITS  = 32,
   parameter int LOSS_COUNT = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 blk_vld,
   input  logic [1:0]           blk_hdr,
   input  logic                 mb_start,
   output logic [WORD_BITS-1:0] sync_word,
   output logic                 word_vld,
   output logic                 hdr_err,
   output logic                 locked
);

   generate
      if (WORD_BITS < 2) begin : g_bad_word
         $error("shdr_word_rx: WORD_BITS must be at least 2");
      end
      if (LOSS_COUNT < 2) begin : g_bad_loss
         $error("shdr_word_rx: LOSS_COUNT must be at least 2");
      end
   endgenerate

   logic dec_bit, dec_bad, lose, err_q;

   shdr_hdr_decode u_dec (
      .blk_vld (blk_vld),
      .hdr_in  (blk_hdr),
      .bit_out (dec_bit),
      .bad_out (dec_bad)
   );

   shdr_lock_track #(.LOSS_COUNT(LOSS_COUNT)) u_lock (
      .clk      (clk),
      .rst_n    (rst_n),
      .blk_vld  (blk_vld),
      .start    (mb_start),
      .bad      (dec_bad),
      .locked_o (locked),
      .lose_o   (lose)
   );

   shdr_word_collect #(.WORD_BITS(WORD_BITS)) u_col (
      .clk     (clk),
      .rst_n   (rst_n),
      .blk_vld (blk_vld),
      .start   (mb_start),
      .bit_in  (dec_bit),
      .lose    (lose),
      .word_o  (sync_word),
      .vld_o   (word_vld)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) err_q <= 1'b0;
      else        err_q <= dec_bad;
   end
   assign hdr_err = err_q;

   // R2
   bad_hdr_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      blk_vld && (blk_hdr == 2'b00 || blk_hdr == 2'b11) |=> hdr_err);

   // R9
   idle_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !blk_vld |=> !hdr_err);

   // R7
   regain_chk: assert property (@(posedge clk) disable iff (!rst_n)
      blk_vld && mb_start |=> locked);

   // R7
   stay_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !locked && !(blk_vld && mb_start) |=> !locked);

   // R7
   word_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      word_vld |-> locked);

endmodule

// File: tb/test_shdr_word_rx.sv
module test_shdr_word_rx;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        blk_vld = 1'b0;
   logic [1:0]  blk_hdr = 2'b00;
   logic        mb_start = 1'b0;
   logic [31:0] sync_word;
   logic        word_vld, hdr_err, locked;

   int total = 0;
   int bad = 0;
   int vld_seen = 0;

   logic        m_locked = 1'b0, m_err = 1'b0, m_vld = 1'b0, m_active = 1'b0;
   logic [31:0] m_sh = '0, m_word = '0;
   int          m_idx = 0, m_run = 0;

   always #2 clk = ~clk;

   shdr_word_rx i_shdr_word_rx (
      .clk(clk), .rst_n(rst_n), .blk_vld(blk_vld), .blk_hdr(blk_hdr),
      .mb_start(mb_start), .sync_word(sync_word), .word_vld(word_vld),
      .hdr_err(hdr_err), .locked(locked)
   );

   function automatic logic [1:0] hdr_of(input logic b);
      return b ? 2'b10 : 2'b01;
   endfunction

   function automatic logic is_bad(input logic [1:0] h);
      return (h == 2'b00) || (h == 2'b11);
   endfunction

   task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic model_step(input logic v, input logic [1:0] h, input logic s);
      logic b, lose;
      b     = v && is_bad(h);
      m_err = b;
      m_vld = 1'b0;
      if (v) begin
         if (s) begin
            m_run = b ? 1 : 0;
            m_locked = 1'b1;
            m_active = 1'b1;
            m_idx = 1;
            m_sh = {31'd0, h == 2'b10};
         end else begin
            m_run = b ? ((m_run == 16) ? 16 : m_run + 1) : 0;
            lose = b && (m_run == 16);
            if (lose) begin
               m_locked = 1'b0;
               m_active = 1'b0;
            end else if (m_active) begin
               m_sh = {m_sh[30:0], h == 2'b10};
               m_idx++;
               if (m_idx == 32) begin
                  m_word = m_sh;
                  m_vld = 1'b1;
                  m_active = 1'b0;
               end
            end
         end
      end
   endtask

   task automatic blk(input logic v, input logic [1:0] h, input logic s);
      blk_vld = v; blk_hdr = h; mb_start = s;
      @(posedge clk);
      model_step(v, h, s);
      @(negedge clk);
      if (word_vld) vld_seen++;
      chk(hdr_err === m_err, "R2 hdr_err", 32'(hdr_err), 32'(m_err));
      chk(locked === m_locked, "R6 locked", 32'(locked), 32'(m_locked));
      chk(word_vld === m_vld, "R4 word_vld", 32'(word_vld), 32'(m_vld));
      chk(sync_word === m_word, "R3 sync_word", sync_word, m_word);
   endtask

   task automatic send_word(input logic [31:0] w, input logic gaps);
      for (int i = 0; i < 32; i++) begin
         if (gaps && (i % 7 == 3)) blk(1'b0, 2'b00, 1'b1);
         blk(1'b1, hdr_of(w[31-i]), i == 0);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      $display("FAIL watchdog expired act=%0d exp=%0d", total, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int n;
      int pos;
      int burst;
      logic [31:0] w;
      logic        v, s;
      logic [1:0]  h;
      int          r;
      pos = 0;
      burst = 0;
      r = $urandom(32'd2024);
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R8 reset state
      chk(locked === 1'b0, "R8 locked", 32'(locked), 0);
      chk(word_vld === 1'b0, "R8 word_vld", 32'(word_vld), 0);
      chk(hdr_err === 1'b0, "R8 hdr_err", 32'(hdr_err), 0);
      chk(sync_word === 32'd0, "R8 sync_word", sync_word, 0);

      // R1 R3: MSB-first decode of a mixed pattern
      w = 32'hA5C3_0F96;
      send_word(w, 1'b0);
      chk(sync_word === w, "R1 word decode", sync_word, w);
      chk(vld_seen == 1, "R4 one pulse", 32'(vld_seen), 1);

      // R9: idle cycles with junk header and start strobe
      w = 32'h3C5A_F00D;
      send_word(w, 1'b1);
      chk(sync_word === w, "R9 idle ignored", sync_word, w);

      // R10: trailing blocks not collected
      n = vld_seen;
      for (int i = 0; i < 5; i++) blk(1'b1, 2'b10, 1'b0);
      chk(vld_seen == n, "R10 no extra word", 32'(vld_seen), 32'(n));
      chk(sync_word === w, "R10 word kept", sync_word, w);

      // R2: illegal header recorded as zero
      for (int i = 0; i < 32; i++)
         blk(1'b1, (i == 5) ? 2'b11 : ((i == 9) ? 2'b00 : 2'b10), i == 0);
      chk(sync_word === 32'hFBBF_FFFF, "R2 bad as zero", sync_word, 32'hFBBF_FFFF);

      // R5: cut-off partial word
      n = vld_seen;
      for (int i = 0; i < 10; i++) blk(1'b1, 2'b10, i == 0);
      w = 32'h1234_8765;
      send_word(w, 1'b0);
      chk(vld_seen == n + 1, "R5 partial dropped", 32'(vld_seen), 32'(n + 1));
      chk(sync_word === w, "R5 restart word", sync_word, w);

      // R6: 15 bad keep lock, legal header resets run, 16 bad lose it
      for (int i = 0; i < 15; i++) blk(1'b1, 2'b00, 1'b0);
      chk(locked === 1'b1, "R6 fifteen kept", 32'(locked), 1);
      blk(1'b1, 2'b01, 1'b0);
      for (int i = 0; i < 15; i++) blk(1'b1, 2'b11, 1'b0);
      chk(locked === 1'b1, "R6 run reset", 32'(locked), 1);
      blk(1'b1, 2'b11, 1'b0);
      chk(locked === 1'b0, "R6 sixteen lost", 32'(locked), 0);

      // R7: no regain without start, no words while down
      n = vld_seen;
      for (int i = 0; i < 40; i++) blk(1'b1, 2'b10, 1'b0);
      chk(locked === 1'b0, "R7 stays down", 32'(locked), 0);
      chk(vld_seen == n, "R7 no word unlocked", 32'(vld_seen), 32'(n));
      blk(1'b1, 2'b10, 1'b1);
      chk(locked === 1'b1, "R7 regained", 32'(locked), 1);

      // random phase
      for (int c = 0; c < 6000; c++) begin
         v = ($urandom % 10) < 8;
         if (burst > 0) begin
            h = ($urandom % 2) ? 2'b00 : 2'b11;
            if (v) burst--;
         end else begin
            r = $urandom % 100;
            if (r < 4) h = (r < 2) ? 2'b00 : 2'b11;
            else h = hdr_of($urandom % 2 == 1);
         end
         s = v && ((pos == 0) || ($urandom % 150 == 0));
         if (v) pos = s ? 1 : (pos + 1) % 32;
         if ($urandom % 300 == 0) burst = 18;
         blk(v, h, s);
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule